// File: doc/BRIEF.md
# Sparse Activation Scan and Broadcast Unit

This unit holds one dense input activation vector of 16-bit fixed-point values and walks it in index order, skipping every zero entry. The vector slots are grouped four at a time under four-input leading-non-zero nodes. The nodes are stacked into a quadtree whose root names the lowest-indexed non-zero slot still waiting to be sent. On each cycle of the scan the unit sends that slot's value and its index to the activation queue of every processing element. The processing elements themselves are outside this unit and appear only as consumers that pop their own queues.

A controller runs two modes. In I/O mode the scan is idle and the activation storage takes writes from outside. A start pulse captures the programmed input length and enters compute mode. Compute mode sends non-zeros until no slot below the length is left, then waits for every queue to empty and raises a completion flag. If any queue is full, the broadcast is held for all of them. The unit is back in I/O mode once it completes, and a new start begins the next layer.

Top module: `act_bcast`

## Requirements
- R1: After reset the unit is in I/O mode (`io_mode` high), `done` is low and every queue is empty (`pe_valid` all zero).
- R2: A write to the activation storage takes effect only in I/O mode. `io_mode` is low for the whole of compute mode, and a write issued then leaves the stored vector unchanged for later layers.
- R3: Every non-zero slot whose index is below the captured length reaches every processing-element queue exactly once, with its value on `pe_act` and its index on `pe_idx`. Zero slots and slots at or above the length are never sent.
- R4: Entries are sent in strictly increasing index order. When several slots are pending, the lowest index wins, both inside a group of four and between groups.
- R5: Each queue holds 8 entries. No broadcast takes place while any queue is full, and no entry is lost to the stall.
- R6: Each processing element pops its own queue at its own pace and sees its entries in order. A pop on an empty queue has no effect.
- R7: `done` rises only after the last non-zero has been sent and every queue is empty. The unit is then in I/O mode, and `done` stays high until the next start.
- R8: A length of zero, or a vector with no non-zero slot below the length, completes with no entry sent.
- R9: The length is sampled from `cfg_len` on the start pulse. A change of `cfg_len` during compute mode does not alter the layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Activation storage write strobe (I/O mode only) |
| wr_addr | input | IDXW (4) | Slot index written |
| wr_data | input | 16 | Activation value written |
| cfg_len | input | IDXW+1 (5) | Input length; slots with index below it are scanned |
| start | input | 1 | Starts a layer from I/O mode |
| pe_pop | input | N_PE (8) | Bit p pops the head of queue p |
| pe_valid | output | N_PE (8) | Bit p: queue p is non-empty |
| pe_act | output | N_PE*16 | Head value of queue p at bits [16p+15:16p] |
| pe_idx | output | N_PE*IDXW | Head index of queue p at bits [IDXW*p+IDXW-1:IDXW*p] |
| io_mode | output | 1 | High in I/O mode, low in compute mode |
| done | output | 1 | Layer completed and all queues drained |

## Verification
The scan is first driven with every single-slot vector, which shows that each leaf position of the tree can win and that its index is encoded correctly. A fixed sparse vector is then swept through every length from 0 to 16, which separates the length cut-off from the detection itself. Hand-picked patterns place non-zeros within one group of four, across group borders and at both ends of the vector, to test lowest-index priority at both tree levels. A fully dense vector with consumers held back forces the queues to fill and shows the global stall and the loss-free resume. Uneven per-element pop rates, a write during compute and a length change during compute separate the independent queues from the mode and capture rules.

// File: rtl/ab_pkg.sv
package ab_pkg;
  localparam int ACT_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } ab_state_t;
endpackage

// File: rtl/ab_lnz_node.sv
module ab_lnz_node #(
  parameter int W  = 4,
  parameter int SH = 0
) (
  input  logic [3:0]        cv,
  input  logic [3:0][W-1:0] cix,
  output logic              ov,
  output logic [W-1:0]      oix
);
  logic [1:0] sel;

  always_comb begin
    if (cv[0])      sel = 2'd0;
    else if (cv[1]) sel = 2'd1;
    else if (cv[2]) sel = 2'd2;
    else            sel = 2'd3;
  end

  assign ov  = |cv;
  assign oix = (W'(sel) << SH) | cix[sel];
endmodule

// File: rtl/ab_detect_tree.sv
module ab_detect_tree #(
  parameter int LEVELS = 2,
  localparam int VEC_MAX = 4 ** LEVELS,
  localparam int IDXW = 2 * LEVELS
) (
  input  logic [VEC_MAX-1:0] leaf,
  output logic               found,
  output logic [IDXW-1:0]    idx
);
  logic            vld [LEVELS+1][VEC_MAX];
  logic [IDXW-1:0] ix  [LEVELS+1][VEC_MAX];

  for (genvar i = 0; i < VEC_MAX; i++) begin : g_leaf
    assign vld[0][i] = leaf[i];
    assign ix[0][i]  = '0;
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NN = VEC_MAX >> (2 * (l + 1));
    for (genvar k = 0; k < NN; k++) begin : g_node
      ab_lnz_node #(.W(IDXW), .SH(2 * l)) u_node (
        .cv  ({vld[l][4*k+3], vld[l][4*k+2], vld[l][4*k+1], vld[l][4*k]}),
        .cix ({ix[l][4*k+3],  ix[l][4*k+2],  ix[l][4*k+1],  ix[l][4*k]}),
        .ov  (vld[l+1][k]),
        .oix (ix[l+1][k])
      );
    end
    for (genvar k = NN; k < VEC_MAX; k++) begin : g_tie
      assign vld[l+1][k] = 1'b0;
      assign ix[l+1][k]  = '0;
    end
  end

  assign found = vld[LEVELS][0];
  assign idx   = ix[LEVELS][0];
endmodule

// File: rtl/ab_queue.sv
module ab_queue #(
  parameter int W     = 20,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         valid,
  output logic         full,
  output logic [W-1:0] dout
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign valid   = (cnt_q != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = do_push ? wp_q + PW'(1) : wp_q;
    rp_d  = do_pop  ? rp_q + PW'(1) : rp_q;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/act_bcast.sv
module act_bcast
  import ab_pkg::*;
#(
  parameter int N_PE   = 8,
  parameter int LEVELS = 2,
  parameter int QDEPTH = 8,
  localparam int VEC_MAX = 4 ** LEVELS,
  localparam int IDXW = 2 * LEVELS,
  localparam int LENW = IDXW + 1,
  localparam int EW = ACT_W + IDXW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDXW-1:0]        wr_addr,
  input  logic [ACT_W-1:0]       wr_data,
  input  logic [LENW-1:0]        cfg_len,
  input  logic                   start,
  input  logic [N_PE-1:0]        pe_pop,
  output logic [N_PE-1:0]        pe_valid,
  output logic [N_PE*ACT_W-1:0]  pe_act,
  output logic [N_PE*IDXW-1:0]   pe_idx,
  output logic                   io_mode,
  output logic                   done
);
  ab_state_t        st_q, st_d;
  logic [LENW-1:0]  cur_q, cur_d;
  logic [LENW-1:0]  len_q, len_d;
  logic [ACT_W-1:0] act_q [VEC_MAX];
  logic [VEC_MAX-1:0] leaf;
  logic             found;
  logic [IDXW-1:0]  bc_idx;
  logic [ACT_W-1:0] bc_val;
  logic             bc_push;
  logic [N_PE-1:0]  q_full;
  logic             any_full, all_empty, wr_ok;

  assign io_mode = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign done    = (st_q == ST_DONE);
  assign wr_ok   = wr_en && io_mode;

  always_ff @(posedge clk) begin
    if (wr_ok) act_q[wr_addr] <= wr_data;
  end

  for (genvar i = 0; i < VEC_MAX; i++) begin : g_mask
    assign leaf[i] = (act_q[i] != '0) && (LENW'(i) >= cur_q) && (LENW'(i) < len_q);
  end

  ab_detect_tree #(.LEVELS(LEVELS)) u_tree (
    .leaf  (leaf),
    .found (found),
    .idx   (bc_idx)
  );

  assign bc_val    = act_q[bc_idx];
  assign any_full  = |q_full;
  assign all_empty = ~|pe_valid;

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    len_d   = len_q;
    bc_push = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          st_d  = ST_SCAN;
          cur_d = '0;
          len_d = cfg_len;
        end
      end
      ST_SCAN: begin
        if (!found) begin
          st_d = ST_DRAIN;
        end else if (!any_full) begin
          bc_push = 1'b1;
          cur_d   = LENW'(bc_idx) + LENW'(1);
        end
      end
      ST_DRAIN: begin
        if (all_empty) st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      len_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      len_q <= len_d;
    end
  end

  for (genvar p = 0; p < N_PE; p++) begin : g_pe
    logic [EW-1:0] head;
    ab_queue #(.W(EW), .DEPTH(QDEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (bc_push),
      .din   ({bc_idx, bc_val}),
      .pop   (pe_pop[p]),
      .valid (pe_valid[p]),
      .full  (q_full[p]),
      .dout  (head)
    );
    assign pe_act[p*ACT_W +: ACT_W] = head[ACT_W-1:0];
    assign pe_idx[p*IDXW +: IDXW]   = head[EW-1:ACT_W];
  end
endmodule

// File: rtl/ab_checker.sv
module ab_checker #(
  parameter int N_PE  = 8,
  parameter int IDXW  = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_mode,
  input logic             done,
  input logic             push,
  input logic [IDXW-1:0]  push_idx,
  input logic [15:0]      push_val,
  input logic [IDXW:0]    len_q,
  input logic [N_PE-1:0]  pe_pop,
  input logic [N_PE-1:0]  pe_valid
);
  logic            have_last;
  logic [IDXW-1:0] last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_idx  <= '0;
    end else if (io_mode) begin
      have_last <= 1'b0;
    end else if (push) begin
      have_last <= 1'b1;
      last_idx  <= push_idx;
    end
  end

  assert_drained_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pe_valid == '0));

  assert_sent_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (({1'b0, push_idx} < len_q) && (push_val != '0)));

  assert_rising_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && have_last) |-> (push_idx > last_idx));

  assert_quiet_in_io_R2: assert property (@(posedge clk) disable iff (!rst_n)
    io_mode |-> !push);

  for (genvar i = 0; i < N_PE; i++) begin : g_occ
    logic [7:0] occ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + 8'(push) - 8'(pe_pop[i] && pe_valid[i]);
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= 8'(DEPTH));

    assert_head_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_valid[i] && !pe_pop[i]) |=> pe_valid[i]);
  end
endmodule

bind act_bcast ab_checker #(.N_PE(N_PE), .IDXW(IDXW), .DEPTH(QDEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_mode  (io_mode),
  .done     (done),
  .push     (bc_push),
  .push_idx (bc_idx),
  .push_val (bc_val),
  .len_q    (len_q),
  .pe_pop   (pe_pop),
  .pe_valid (pe_valid)
);

// File: tb/sim_act_bcast.sv
module sim_act_bcast;
  localparam int N_PE = 8;
  localparam int IDXW = 4;
  localparam int VEC  = 16;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 wr_en;
  logic [IDXW-1:0]      wr_addr;
  logic [15:0]          wr_data;
  logic [IDXW:0]        cfg_len;
  logic                 start;
  logic [N_PE-1:0]      pe_pop;
  logic [N_PE-1:0]      pe_valid;
  logic [N_PE*16-1:0]   pe_act;
  logic [N_PE*IDXW-1:0] pe_idx;
  logic                 io_mode;
  logic                 done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [15:0] ref_v [VEC];
  int          exp_i [VEC];
  logic [15:0] exp_v [VEC];
  int          nexp;
  int          ptr [N_PE];

  act_bcast #(.N_PE(N_PE), .LEVELS(2), .QDEPTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_len(cfg_len), .start(start), .pe_pop(pe_pop),
    .pe_valid(pe_valid), .pe_act(pe_act), .pe_idx(pe_idx),
    .io_mode(io_mode), .done(done)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] vof(input int i, input int seed);
    return 16'(i * 291 + seed * 1105 + 7) | 16'h0001;
  endfunction

  task automatic load(input logic [15:0] mask, input int seed);
    for (int i = 0; i < VEC; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = IDXW'(i);
      wr_data = mask[i] ? vof(i, seed) : 16'h0000;
      ref_v[i] = wr_data;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int len, input int pol, input bit poke, input string req);
    bit fin = 0;
    nexp = 0;
    for (int i = 0; i < VEC; i++) begin
      if (i < len && ref_v[i] != 16'h0000) begin
        exp_i[nexp] = i;
        exp_v[nexp] = ref_v[i];
        nexp++;
      end
    end
    for (int p = 0; p < N_PE; p++) ptr[p] = 0;
    @(negedge clk);
    cfg_len = (IDXW+1)'(len);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (cyc == 0) begin
        check(io_mode == 1'b0, "R2", int'(io_mode), 0);
        if (poke) begin
          wr_en   = 1'b1;
          wr_addr = 4'd5;
          wr_data = 16'h7777;
          cfg_len = 5'd16;
        end
      end else begin
        wr_en = 1'b0;
      end
      if (pol == 1 && cyc == 39 && nexp >= 8) begin
        check(pe_valid == '1, "R5", int'(pe_valid), 8'hff);
        check(done == 1'b0, "R7", int'(done), 0);
      end
      if (done) begin
        check(pe_valid == '0, "R7", int'(pe_valid), 0);
        for (int p = 0; p < N_PE; p++)
          check(ptr[p] == nexp, req, ptr[p], nexp);
        fin = 1;
      end else begin
        for (int p = 0; p < N_PE; p++) begin
          bit pop;
          case (pol)
            0:       pop = 1'b1;
            1:       pop = (cyc >= 40);
            default: pop = ((cyc + p) % (p + 2)) == 0;
          endcase
          pe_pop[p] = pop;
          if (pop && pe_valid[p]) begin
            if (ptr[p] < nexp) begin
              check(int'(pe_idx[p*IDXW +: IDXW]) == exp_i[ptr[p]], req,
                    int'(pe_idx[p*IDXW +: IDXW]), exp_i[ptr[p]]);
              check(pe_act[p*16 +: 16] == exp_v[ptr[p]], req,
                    int'(pe_act[p*16 +: 16]), int'(exp_v[ptr[p]]));
            end else begin
              check(1'b0, req, ptr[p] + 1, nexp);
            end
            ptr[p]++;
          end
        end
      end
    end
    pe_pop = '0;
    check(fin == 1, "R7 completion", int'(fin), 1);
    @(negedge clk);
    check(io_mode == 1'b1, "R7", int'(io_mode), 1);
    check(done == 1'b1, "R7", int'(done), 1);
  endtask

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    cfg_len = '0;
    start   = 1'b0;
    pe_pop  = '0;
    repeat (3) @(negedge clk);
    check(io_mode == 1'b1, "R1", int'(io_mode), 1);
    check(done == 1'b0, "R1", int'(done), 0);
    check(pe_valid == '0, "R1", int'(pe_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(io_mode == 1'b1 && pe_valid == '0, "R1", int'(pe_valid), 0);

    // R3 R4: each single slot in turn, all four groups and every leaf
    for (int b = 0; b < VEC; b++) begin
      load(16'(1 << b), b);
      run(16, 0, 0, "R3");
    end

    // R8 R3: length sweep over one sparse pattern, including zero length
    load(16'hA5C3, 7);
    for (int len = 0; len <= VEC; len++) run(len, 0, 0, "R8");

    // R8: all-zero vector
    load(16'h0000, 1);
    run(16, 0, 0, "R8");

    // R4 R6: priority inside a group and across group borders, uneven pops
    load(16'h0006, 2);  run(16, 2, 0, "R4");
    load(16'h0018, 3);  run(16, 2, 0, "R4");
    load(16'h8001, 4);  run(16, 2, 0, "R4");
    load(16'hF00F, 5);  run(16, 2, 0, "R6");
    load(16'h5A5A, 6);  run(14, 2, 0, "R6");

    // R5: dense vector with consumers held back until queues fill
    load(16'hFFFF, 8);
    run(16, 1, 0, "R5");

    // R2 R9: write and length change during compute are ignored
    load(16'hFF0F, 9);
    run(12, 2, 1, "R9");
    run(12, 0, 0, "R2");
    run(16, 0, 0, "R2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule